// File: doc/BRIEF.md
# Dual-Compare Timer with Clocked Outputs

This block is a free-running timer for event scheduling. The peripheral clock is halved and then divided again by a programmable ratio. The result is a count enable that advances a 10-bit wrapping counter. Two comparators watch the counter. Each one fires a single-cycle match pulse and sets a sticky interrupt flag when the counter reaches that comparator's active match value.

Software programs each match value through a staging copy. The staged value takes over only when the comparator's current match happens. This lets an interrupt routine set up the next event time while the present one is still pending. An output port holds staged bits and drives them onto its pins at the match pulse of the comparator chosen for it. Port changes are therefore timed to the count rather than to software.

The counter is read over a byte-wide register bus as two separate bytes, an upper byte and a lower byte. A wide read returns two neighbouring registers at once. Separate byte reads are not latched together, so they can straddle a carry.

Top module: `dual_match_timer`

## Requirements
- R1: After synchronous reset: the counter is 0, both flags are clear, `irq` is 0, the pins are 0, and both match registers read back 0x3FF (low byte 0xFF, high byte 0x03).
- R2: With the ratio register (address 2) set to N, the counter advances by exactly one every 2*(N+1) clock cycles.
- R3: The counter is 10 bits wide and wraps from 1023 to 0.
- R4: A comparator's `match_pulse` bit (bit 0 = comparator A, bit 1 = comparator B) is high for exactly one cycle, in the cycle where the counter first shows the active match value. It stays low while the counter holds that value.
- R5: Writing a match value updates only the staging copy. Comparator A's staging is written at addresses 4 (bits 7:0) and 5 (bits 9:8); comparator B's at 6 and 7, and these addresses read back the staged value. The staged value becomes active at that comparator's next match pulse.
- R6: A match pulse sets that comparator's flag in the status register (address 3; bit 0 = A, bit 1 = B) in the same cycle the pulse appears. `irq` is high while any flag is set.
- R7: A read strobe at the status address clears both flags at the next edge. A flag whose match pulse arrives at that same edge stays set.
- R8: The pins load the port staging byte (address 8) on the match pulse of the comparator picked by bit 0 of address 9 (0 = A, 1 = B). On any other cycle, including a pulse from the other comparator, the pins do not change.
- R9: `bus_rdata[7:0]` holds the register at `bus_addr`, and `bus_rdata[15:8]` holds the register at `bus_addr`+1. A wide read at address 0 therefore gives the upper count bits in the low byte and the lower count byte in the high byte.
- R10: Address 0 returns count bits 9:8 and address 1 returns count bits 7:0, taken live at each access. A lower-byte read of 0xFF followed by an upper-byte read after the carry yields the torn pair 0x01/0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for `bus_addr` |
| bus_rd | input | 1 | Read strobe (clears status when at address 3) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | {register at addr+1, register at addr} |
| out_pins | output | 8 | Clocked output port |
| match_pulse | output | 2 | One-cycle match pulses, bit 0 = A, bit 1 = B |
| irq | output | 1 | Interrupt request, OR of both flags |

## Verification
Every cycle, the assertions check three things. The counter only steps by one modulo 1024. A pulse never lasts two cycles and coincides with the previously active value. The active value changes only on its own pulse. They also check that the pins are frozen without a pulse, that a pulse always raises `irq`, and that a status read leaves `irq` equal to the pulse of that edge. Only the bench scenarios can show the exact divide period for several ratios, and the delay of a staged match value by a full counter cycle. The same holds for the flag surviving a clear at the same edge, the pins ignoring the unselected comparator, and the torn read across the 0xFF-to-0x100 carry.

// File: rtl/dmt_pkg.sv
`timescale 1ns/1ps
package dmt_pkg;
    typedef logic [3:0] reg_addr_t;

    localparam reg_addr_t ADDR_CNT_HI    = 4'd0;
    localparam reg_addr_t ADDR_CNT_LO    = 4'd1;
    localparam reg_addr_t ADDR_RATIO     = 4'd2;
    localparam reg_addr_t ADDR_STATUS    = 4'd3;
    localparam reg_addr_t ADDR_A_LO      = 4'd4;
    localparam reg_addr_t ADDR_A_HI      = 4'd5;
    localparam reg_addr_t ADDR_OUT_STAGE = 4'd8;
    localparam reg_addr_t ADDR_OUT_SEL   = 4'd9;
    localparam int        NUM_REGS       = 16;
    localparam int        NUM_CMP        = 2;
endpackage

// File: rtl/dmt_prescaler.sv
`timescale 1ns/1ps
module dmt_prescaler #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    typedef struct packed {
        logic               half;
        logic [RATIO_W-1:0] div;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        tick      = 1'b0;
        st_d.half = ~st_q.half;
        if (st_q.half) begin
            // >= keeps the divider bounded if the ratio shrinks mid-count
            if (st_q.div >= ratio) begin
                tick     = 1'b1;
                st_d.div = '0;
            end else begin
                st_d.div = st_q.div + RATIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dmt_comparator.sv
`timescale 1ns/1ps
module dmt_comparator #(
    parameter int CNT_W = 10,
    localparam int HI_W = CNT_W - 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata_lo,
    input  logic [HI_W-1:0]  wdata_hi,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] stage,
    output logic             hit,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] stage;
        logic             pulse;
    } cmp_t;

    cmp_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        hit        = tick && (cnt_next == st_q.active);
        st_d.pulse = hit;
        if (hit)   st_d.active            = st_q.stage;
        if (wr_lo) st_d.stage[7:0]        = wdata_lo;
        if (wr_hi) st_d.stage[CNT_W-1:8]  = wdata_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= '1;
            st_q.stage  <= '1;
            st_q.pulse  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign stage  = st_q.stage;
    assign pulse  = st_q.pulse;
endmodule

// File: rtl/dual_match_timer.sv
`timescale 1ns/1ps
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int RATIO_W = 8,
    parameter int PORT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [PORT_W-1:0] out_pins,
    output logic [1:0]        match_pulse,
    output logic              irq
);
    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [RATIO_W-1:0] ratio;
        logic [NUM_CMP-1:0] flags;
        logic [PORT_W-1:0]  stage;
        logic               sel;
        logic [PORT_W-1:0]  pins;
    } top_t;

    top_t st_d, st_q;

    logic                           tick;
    logic [CNT_W-1:0]               cnt_next;
    logic [NUM_CMP-1:0]             hit;
    logic [NUM_CMP-1:0]             pulse;
    logic [NUM_CMP-1:0]             wr_lo;
    logic [NUM_CMP-1:0]             wr_hi;
    logic [NUM_CMP-1:0][CNT_W-1:0]  act;
    logic [NUM_CMP-1:0][CNT_W-1:0]  stg;
    logic [7:0]                     rbank [NUM_REGS];
    logic [3:0]                     addr_nx;
    logic                           rd_clear;
    logic                           port_hit;

    dmt_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .ratio (st_q.ratio),
        .tick  (tick)
    );

    assign cnt_next = tick ? st_q.cnt + CNT_W'(1) : st_q.cnt;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        assign wr_lo[i] = bus_wr && (bus_addr == 4'(ADDR_A_LO + 2 * i));
        assign wr_hi[i] = bus_wr && (bus_addr == 4'(ADDR_A_HI + 2 * i));

        dmt_comparator #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt_next (cnt_next),
            .wr_lo    (wr_lo[i]),
            .wr_hi    (wr_hi[i]),
            .wdata_lo (bus_wdata),
            .wdata_hi (bus_wdata[HI_W-1:0]),
            .active   (act[i]),
            .stage    (stg[i]),
            .hit      (hit[i]),
            .pulse    (pulse[i])
        );
    end

    // read bank: every address yields a byte, unmapped ones read zero
    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) rbank[k] = '0;
        rbank[ADDR_CNT_HI][HI_W-1:0]   = st_q.cnt[CNT_W-1:8];
        rbank[ADDR_CNT_LO]             = st_q.cnt[7:0];
        rbank[ADDR_RATIO][RATIO_W-1:0] = st_q.ratio;
        rbank[ADDR_STATUS][NUM_CMP-1:0] = st_q.flags;
        for (int i = 0; i < NUM_CMP; i++) begin
            rbank[4'(ADDR_A_LO + 2 * i)]           = stg[i][7:0];
            rbank[4'(ADDR_A_HI + 2 * i)][HI_W-1:0] = stg[i][CNT_W-1:8];
        end
        rbank[ADDR_OUT_STAGE][PORT_W-1:0] = st_q.stage;
        rbank[ADDR_OUT_SEL][0]            = st_q.sel;
    end

    assign addr_nx   = bus_addr + 4'd1;
    assign bus_rdata = {rbank[addr_nx], rbank[bus_addr]};
    assign rd_clear  = bus_rd && (bus_addr == ADDR_STATUS);
    assign port_hit  = st_q.sel ? hit[1] : hit[0];

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = cnt_next;
        st_d.flags = (rd_clear ? '0 : st_q.flags) | hit;
        if (port_hit) st_d.pins = st_q.stage;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_RATIO:     st_d.ratio = bus_wdata[RATIO_W-1:0];
                ADDR_OUT_STAGE: st_d.stage = bus_wdata[PORT_W-1:0];
                ADDR_OUT_SEL:   st_d.sel   = bus_wdata[0];
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_pins    = st_q.pins;
    assign match_pulse = pulse;
    assign irq         = |st_q.flags;
endmodule

// File: rtl/dmt_checks.sv
`timescale 1ns/1ps
module dmt_checks
    import dmt_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [3:0]        bus_addr,
    input logic [1:0]        match_pulse,
    input logic              irq,
    input logic [PORT_W-1:0] out_pins,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  active_a,
    input logic [CNT_W-1:0]  active_b
);
    // R2 / R3: counter moves only by +1 modulo 2^CNT_W
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

    // R4: pulses never last two cycles
    p_pulse_a_single_r4: assert property (@(posedge clk) disable iff (rst)
        match_pulse[0] |=> !match_pulse[0]);
    p_pulse_b_single_r4: assert property (@(posedge clk) disable iff (rst)
        match_pulse[1] |=> !match_pulse[1]);

    // R4: a pulse shows the counter at the value that was active
    p_pulse_a_value_r4: assert property (@(posedge clk) disable iff (rst)
        match_pulse[0] |-> (count == $past(active_a)));
    p_pulse_b_value_r4: assert property (@(posedge clk) disable iff (rst)
        match_pulse[1] |-> (count == $past(active_b)));

    // R5: active value changes only together with its own pulse
    p_active_a_buffered_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_a) |-> match_pulse[0]);
    p_active_b_buffered_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_b) |-> match_pulse[1]);

    // R6: a pulse always comes with an interrupt request
    p_irq_on_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (|match_pulse) |-> irq);

    // R7: after a status read only same-edge pulses keep irq up
    p_status_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == ADDR_STATUS)) |=> (irq == (|match_pulse)));

    // R8: the pins move only with a match pulse
    p_pins_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (match_pulse == 2'b00) |-> $stable(out_pins));
endmodule

bind dual_match_timer dmt_checks #(.CNT_W(CNT_W), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .match_pulse (match_pulse),
    .irq         (irq),
    .out_pins    (out_pins),
    .count       (st_q.cnt),
    .active_a    (act[0]),
    .active_b    (act[1])
);

// File: tb/dual_match_timer_tb.sv
`timescale 1ns/100ps
module dual_match_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  out_pins;
    logic [1:0]  match_pulse;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_match_timer u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .out_pins    (out_pins),
        .match_pulse (match_pulse),
        .irq         (irq)
    );

    // {ratio, expected count delta, clocks waited} with clocks = 2*(ratio+1)*delta
    localparam logic [31:0] VEC [6] = '{
        {8'd0,   8'd5, 16'd10},
        {8'd1,   8'd4, 16'd16},
        {8'd3,   8'd3, 16'd24},
        {8'd9,   8'd2, 16'd40},
        {8'd2,   8'd7, 16'd42},
        {8'd255, 8'd1, 16'd512}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic get_cnt(output logic [9:0] c);
        logic [15:0] d;
        rd(4'd0, d);
        c = {d[1:0], d[15:8]};
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic clr_status;
        bus_addr = 4'd3;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic wait_change(output logic [9:0] c);
        logic [9:0] p;
        get_cnt(p);
        c = p;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            #1;
            get_cnt(c);
            if (c != p) return;
        end
        chk("R2 counter stalled", 0, 1);
    endtask

    task automatic wait_for(input logic [9:0] v);
        logic [9:0] c;
        for (int n = 0; n < 1100; n++) begin
            wait_change(c);
            if (c == v) return;
        end
        chk("R3 value never reached", 0, int'(v));
    endtask

    task automatic wait_pulse(input int idx, output logic [9:0] c);
        c = '0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            #1;
            if (match_pulse[idx]) begin
                get_cnt(c);
                return;
            end
        end
        chk("R4 pulse never seen", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [9:0]  c0, c1, c;
        logic [9:0]  dlt;
        logic [7:0]  lo;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1: reset state
        get_cnt(c);
        chk("R1 count", c, 0);
        rd(4'd3, d);
        chk("R1 status", d[7:0], 0);
        chk("R1 irq", irq, 0);
        chk("R1 pins", out_pins, 0);
        rd(4'd4, d);
        chk("R1 match A readback", d, 16'h03FF);
        rd(4'd6, d);
        chk("R1 match B readback", d, 16'h03FF);

        // R2: divide period for several ratios, table driven
        foreach (VEC[i]) begin
            wr(4'd2, VEC[i][31:24]);
            wait_change(c0);
            repeat (int'(VEC[i][15:0])) @(negedge clk);
            #1;
            get_cnt(c1);
            dlt = c1 - c0;
            chk($sformatf("R2 ratio %0d delta", VEC[i][31:24]), dlt, VEC[i][23:16]);
        end

        // R5 / R4 / R3 at fastest rate
        wr(4'd2, 8'd0);
        wr(4'd4, 8'h0A);
        wr(4'd5, 8'h00);
        rd(4'd4, d);
        chk("R9 wide read of staged A", d, 16'h000A);
        wait_pulse(0, c);
        chk("R5 staged value not yet active", c, 10'h3FF);
        chk("R4 both pulses at 1023", match_pulse, 2'b11);
        @(negedge clk);
        #1;
        chk("R4 pulse lasts one cycle", match_pulse, 2'b00);
        wait_change(c);
        chk("R3 wrap to zero", c, 0);
        wait_pulse(0, c);
        chk("R5 new value active after match", c, 10);

        // R4: slow rate, pulse does not persist while the count holds
        wr(4'd2, 8'd3);
        wr(4'd4, 8'h14);
        wait_pulse(0, c);
        chk("R5 second stage waits for match", c, 10);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            #1;
            chk("R4 no repeat pulse while held", match_pulse[0], 0);
        end
        get_cnt(c);
        chk("R4 count still held", c, 10);
        wait_pulse(0, c);
        chk("R5 match at 0x14", c, 20);
        wr(4'd2, 8'd0);

        // R6 / R7: flags, clear, and set at the clearing edge
        clr_status;
        rd(4'd3, d);
        chk("R7 status cleared", d[7:0], 0);
        chk("R7 irq low after clear", irq, 0);
        wait_for(10'd19);
        @(negedge clk);
        bus_addr = 4'd3;
        bus_rd   = 1'b1;
        #0.2;
        chk("R6 status shows comparator B", bus_rdata[7:0], 8'h02);
        chk("R6 irq high with flag", irq, 1);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk("R4 pulse A at 20", match_pulse[0], 1);
        rd(4'd3, d);
        chk("R7 flag set at clear edge survives", d[7:0], 8'h01);
        chk("R6 irq follows surviving flag", irq, 1);
        clr_status;
        rd(4'd3, d);
        chk("R7 status cleared again", d[7:0], 0);
        chk("R7 irq low again", irq, 0);

        // R8: clocked output port
        wr(4'd4, 8'h80);
        wr(4'd8, 8'hA5);
        wr(4'd9, 8'h00);
        chk("R8 pins wait for pulse", out_pins, 0);
        wait_pulse(0, c);
        chk("R8 pins load on A", out_pins, 8'hA5);
        wr(4'd8, 8'h3C);
        wr(4'd9, 8'h01);
        wait_pulse(0, c);
        chk("R5 A now at 0x80", c, 10'h080);
        chk("R8 unselected pulse ignored", out_pins, 8'hA5);
        wait_pulse(1, c);
        chk("R8 B pulse at 1023", c, 10'h3FF);
        chk("R8 pins load on B", out_pins, 8'h3C);

        // R10 / R9: torn split read across the low-byte carry
        wait_for(10'h0FF);
        rd(4'd1, d);
        lo = d[7:0];
        wait_change(c);
        rd(4'd0, d);
        chk("R10 low byte before carry", lo, 8'hFF);
        chk("R10 high bits after carry", d[7:0], 8'h01);
        chk("R9 wide read after carry", d, 16'h0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule